// File: doc/BRIEF.md
# Keyboard Matrix Scan Front End

This block sits between a keyboard matrix and software that runs the scan loop. It drives up to 18 open-drain column lines and senses up to 8 active-low row lines. Software picks the column pattern with a drive command. The choices are to release every column, to pull every column low, or to pull exactly one column low. It then reads the row state back in pressed-is-one form. The 24 column bits live in three byte registers that also carry general-purpose output bits. A fixed parameter mask marks which bits belong to the keyboard. A drive command touches only those bits, and a direct byte write touches only the others.

A wake detector watches each synchronized row line for a falling edge. The status bits are cleared by writing one. An interrupt is raised while the block is in detect mode and an enabled status bit is pending. Entering detect mode clears every pending status bit first, so stale events never fire. Scan timing, debouncing and key-code mapping are left to software.

Register map (3-bit address, 8-bit data, writes take effect at the clock edge where `wr_en` is high, reads are combinational on `addr`):
0 = column bits 7:0, 1 = column bits 15:8, 2 = column bits 23:16, 3 = drive command (write only, reads 0), 4 = row state (read only), 5 = wake status (write 1 to clear), 6 = wake enable, 7 = detect mode in bit 0.

Top module: `kbs_matrix_if`

## Requirements
- R1: After reset every column bit is 0, so all keyboard columns are pulled low. Wake status, wake enable and detect mode are 0, and `irq` is low.
- R2: Reading address 4 returns the bitwise inverse of `row_n` after a two-flop synchronizer. A pin change applied before clock edge k is visible after edge k+1 and not after edge k. Bits at or above NUM_ROWS read 0.
- R3: Drive command with bits 7:6 = 00 (release all) writes 1 to every enabled column bit.
- R4: Drive command with bits 7:6 = 01 (drive all) writes 0 to every enabled column bit.
- R5: Drive command with bits 7:6 = 10 (single) and column index in bits 4:0 writes the enabled mask XOR one-hot(index) to the enabled bits. An index that is ignored or not below NUM_COLS releases all enabled columns. Bits 7:6 = 11 changes nothing.
- R6: The enabled set is the low NUM_COLS bits minus IGNORE_MASK. A drive command never changes a bit outside it. A write to address 0, 1 or 2 changes only bits outside it.
- R7: A falling edge on a synchronized row (previous 1, now 0) sets that row's status bit one edge after it shows in the readback. A rising edge sets nothing.
- R8: Writing 1 to a status bit clears it. If a new falling edge on that row lands in the same cycle, the bit stays set.
- R9: Writing detect mode from 0 to 1 clears all status bits in the same cycle. A falling edge in that cycle still sets its bit.
- R10: `irq` is high exactly when detect mode is 1 and some status bit is set with its enable bit set. Leaving detect mode drops `irq` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| row_n | input | NUM_ROWS | Row pins, low when a key on a driven column is pressed |
| col_out | output | 24 | Column register contents; 0 pulls the line low, 1 releases it |
| irq | output | 1 | Wake interrupt |

## Verification
Two functions can fall in the same cycle: a software clear of a status bit, and a fresh falling edge on the same row. The clear can come from a write-one-to-clear or from the clear that comes with entering detect mode. The bench provokes the write case by timing the row fall so that the synchronized edge reaches the detector on the same clock edge as the clear write. It then judges by reading back a set status bit and a high interrupt. Drive commands and byte writes on the shared column registers are also interleaved. Every result is compared against a bit-exact expected column word that keeps the non-keyboard bits.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
  localparam int COL_BYTES = 3;
  localparam int COL_W     = 8 * COL_BYTES;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_ALL  = 2'd1,
    DRV_ONE  = 2'd2,
    DRV_RSVD = 2'd3
  } drv_mode_e;

  localparam logic [2:0] A_COL0  = 3'd0;
  localparam logic [2:0] A_COL1  = 3'd1;
  localparam logic [2:0] A_COL2  = 3'd2;
  localparam logic [2:0] A_DRIVE = 3'd3;
  localparam logic [2:0] A_ROWS  = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;
  localparam logic [2:0] A_WEN   = 3'd6;
  localparam logic [2:0] A_DET   = 3'd7;
endpackage

// File: rtl/kbs_col_regs.sv
module kbs_col_regs
  import kbs_pkg::*;
#(
  parameter int          NUM_COLS    = 18,
  parameter logic [17:0] IGNORE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [COL_W-1:0] col_q
);
  localparam logic [COL_W-1:0] EN_MASK =
    ((COL_W'(1) << NUM_COLS) - COL_W'(1)) & ~COL_W'(IGNORE_MASK);

  drv_mode_e        mode;
  logic [4:0]       idx;
  logic             drive_cmd;
  logic [COL_W-1:0] pattern;
  logic [COL_W-1:0] after_cmd;
  logic [COL_W-1:0] col_d;

  assign mode      = drv_mode_e'(wdata[7:6]);
  assign idx       = wdata[4:0];
  assign drive_cmd = wr_en && (addr == A_DRIVE) && (mode != DRV_RSVD);

  always_comb begin
    unique case (mode)
      DRV_NONE: pattern = EN_MASK;
      DRV_ALL:  pattern = '0;
      DRV_ONE:  pattern = EN_MASK ^ (COL_W'(1) << idx);
      default:  pattern = col_q;
    endcase
  end

  assign after_cmd = drive_cmd ? ((col_q & ~EN_MASK) | (pattern & EN_MASK)) : col_q;

  for (genvar b = 0; b < COL_BYTES; b++) begin : g_byte
    localparam logic [7:0] KMASK = EN_MASK[8*b +: 8];
    logic byte_wr;
    assign byte_wr = wr_en && (addr == 3'(b));
    assign col_d[8*b +: 8] = byte_wr ? ((col_q[8*b +: 8] & KMASK) | (wdata & ~KMASK))
                                     : after_cmd[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end
endmodule

// File: rtl/kbs_row_sync.sv
module kbs_row_sync #(
  parameter int NUM_ROWS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] row_n,
  output logic [NUM_ROWS-1:0] row_sync,
  output logic [NUM_ROWS-1:0] fall
);
  logic [NUM_ROWS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= row_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign row_sync = sync_q;
  assign fall     = prev_q & ~sync_q;
endmodule

// File: rtl/kbs_wake.sv
module kbs_wake #(
  parameter int NUM_ROWS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ROWS-1:0] fall,
  input  logic                wr_stat,
  input  logic                wr_wen,
  input  logic                wr_det,
  input  logic [7:0]          wdata,
  output logic [NUM_ROWS-1:0] stat_q,
  output logic [NUM_ROWS-1:0] wen_q,
  output logic                detect_q,
  output logic                irq
);
  logic                enter_det;
  logic [NUM_ROWS-1:0] clr;

  assign enter_det = wr_det && wdata[0] && !detect_q;
  assign clr = (wr_stat ? wdata[NUM_ROWS-1:0] : '0) | (enter_det ? '1 : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      wen_q    <= '0;
      detect_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | fall;
      if (wr_wen) wen_q <= wdata[NUM_ROWS-1:0];
      if (wr_det) detect_q <= wdata[0];
    end
  end

  assign irq = detect_q && |(stat_q & wen_q);
endmodule

// File: rtl/kbs_matrix_if.sv
module kbs_matrix_if
  import kbs_pkg::*;
#(
  parameter int          NUM_COLS    = 18,
  parameter int          NUM_ROWS    = 8,
  parameter logic [17:0] IGNORE_MASK = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic [NUM_ROWS-1:0] row_n,
  output logic [23:0]         col_out,
  output logic                irq
);
  logic [COL_W-1:0]    col_q;
  logic [NUM_ROWS-1:0] row_sync, fall, stat_q, wen_q;
  logic                detect_q;

  kbs_col_regs #(.NUM_COLS(NUM_COLS), .IGNORE_MASK(IGNORE_MASK)) u_cols (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .col_q(col_q)
  );

  kbs_row_sync #(.NUM_ROWS(NUM_ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .row_sync(row_sync), .fall(fall)
  );

  kbs_wake #(.NUM_ROWS(NUM_ROWS)) u_wake (
    .clk(clk), .rst_n(rst_n), .fall(fall),
    .wr_stat(wr_en && addr == A_STAT),
    .wr_wen(wr_en && addr == A_WEN),
    .wr_det(wr_en && addr == A_DET),
    .wdata(wdata), .stat_q(stat_q), .wen_q(wen_q), .detect_q(detect_q), .irq(irq)
  );

  assign col_out = col_q;

  always_comb begin
    unique case (addr)
      A_COL0:  rdata = col_q[7:0];
      A_COL1:  rdata = col_q[15:8];
      A_COL2:  rdata = col_q[23:16];
      A_ROWS:  rdata = 8'(~row_sync);
      A_STAT:  rdata = 8'(stat_q);
      A_WEN:   rdata = 8'(wen_q);
      A_DET:   rdata = {7'd0, detect_q};
      default: rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/kbs_matrix_chk.sv
module kbs_matrix_chk #(
  parameter int          NUM_COLS    = 18,
  parameter int          NUM_ROWS    = 8,
  parameter logic [17:0] IGNORE_MASK = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [2:0]          addr,
  input logic [7:0]          wdata,
  input logic [23:0]         col_q,
  input logic [NUM_ROWS-1:0] fall,
  input logic [NUM_ROWS-1:0] stat_q,
  input logic                detect_q,
  input logic                irq
);
  localparam logic [23:0] EN_MASK = ((24'd1 << NUM_COLS) - 24'd1) & ~24'(IGNORE_MASK);

  // R6: a drive command leaves the general-purpose bits alone
  assert_gpio_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3) |=> ((col_q & ~EN_MASK) == ($past(col_q) & ~EN_MASK)));

  // R7: a status bit only rises where an edge was seen
  assert_stat_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(fall)) == '0));

  // R8: an edge always lands in status, even against a clear
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |=> ((stat_q & $past(fall)) == $past(fall)));

  // R9: entering detect mode with no edge leaves status empty
  assert_enter_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7 && wdata[0] && !detect_q && fall == '0) |=> (stat_q == '0));

  // R10: no interrupt outside detect mode
  assert_irq_needs_detect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> detect_q);
endmodule

bind kbs_matrix_if kbs_matrix_chk #(
  .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .IGNORE_MASK(IGNORE_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .col_q(col_q), .fall(fall), .stat_q(stat_q), .detect_q(detect_q), .irq(irq)
);

// File: tb/test_kbs_matrix_if.sv
module test_kbs_matrix_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] row_n = 8'hFF;
  logic [23:0] col_out;
  logic       irq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  // column 5 ignored: enabled set = 0x03FFDF
  kbs_matrix_if #(.NUM_COLS(18), .NUM_ROWS(8), .IGNORE_MASK(18'h00020)) i_kbs_matrix_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .row_n(row_n), .col_out(col_out), .irq(irq)
  );

  // {drive command, expected column word}
  localparam logic [31:0] VEC [8] = '{
    {8'h00, 24'h03FFDF},   // R3 release all
    {8'h40, 24'h000000},   // R4 drive all
    {8'h80, 24'h03FFDE},   // R5 column 0
    {8'h91, 24'h01FFDF},   // R5 column 17
    {8'h85, 24'h03FFDF},   // R5 ignored column
    {8'h94, 24'h03FFDF},   // R5 out of range
    {8'h89, 24'h03FDDF},   // R5 column 9
    {8'hC0, 24'h03FDDF}    // R5 reserved mode
  };

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, 24'(rdata), 24'(exp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 columns", col_out, 24'h0);
    chk("R1 irq", 24'(irq), 24'h0);
    rd_chk("R1 status", 3'd5, 8'h00);
    rd_chk("R1 enable", 3'd6, 8'h00);
    rd_chk("R1 detect", 3'd7, 8'h00);

    for (int v = 0; v < 8; v++) begin
      wr(3'd3, VEC[v][31:24]);
      chk(VEC[v][31:30] == 2'b00 ? "R3 drive" : VEC[v][31:30] == 2'b01 ? "R4 drive" : "R5 drive",
          col_out, VEC[v][23:0]);
    end

    wr(3'd0, 8'hFF);
    chk("R6 byte0 gpio", col_out, 24'h03FDFF);
    wr(3'd2, 8'hFF);
    chk("R6 byte2 gpio", col_out, 24'hFFFDFF);
    wr(3'd3, 8'h40);
    chk("R6 drive keeps gpio", col_out, 24'hFC0020);
    wr(3'd1, 8'h00);
    chk("R6 byte1 all keyboard", col_out, 24'hFC0020);
    rd_chk("R6 readback byte2", 3'd2, 8'hFC);

    row_n = 8'hF6;
    idle(1);
    rd_chk("R2 not yet", 3'd4, 8'h00);
    idle(1);
    rd_chk("R2 inverted rows", 3'd4, 8'h09);
    row_n = 8'hFF;
    idle(3);
    wr(3'd5, 8'hFF);
    rd_chk("R8 clear all", 3'd5, 8'h00);

    wr(3'd6, 8'hFF);
    row_n = 8'hF7;
    idle(3);
    rd_chk("R7 fall sets", 3'd5, 8'h08);
    chk("R10 no detect", 24'(irq), 24'h0);
    wr(3'd7, 8'h01);
    rd_chk("R9 entry clears", 3'd5, 8'h00);
    chk("R9 irq low", 24'(irq), 24'h0);
    row_n = 8'hFF;
    idle(4);
    rd_chk("R7 rise ignored", 3'd5, 8'h00);

    row_n = 8'hFD;
    idle(3);
    rd_chk("R7 row1 fall", 3'd5, 8'h02);
    chk("R10 irq high", 24'(irq), 24'h1);
    wr(3'd5, 8'h02);
    rd_chk("R8 w1c", 3'd5, 8'h00);
    chk("R10 irq after clear", 24'(irq), 24'h0);

    row_n = 8'hFF;
    idle(4);
    row_n = 8'hFD;
    idle(2);
    wr(3'd5, 8'h02);
    rd_chk("R8 edge wins", 3'd5, 8'h02);
    chk("R8 irq kept", 24'(irq), 24'h1);

    wr(3'd6, 8'h00);
    chk("R10 masked", 24'(irq), 24'h0);
    wr(3'd6, 8'h02);
    chk("R10 unmasked", 24'(irq), 24'h1);
    wr(3'd7, 8'h00);
    chk("R10 leave detect", 24'(irq), 24'h0);
    rd_chk("R10 status kept", 3'd5, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule